// File: doc/BRIEF.md
# Three-ADC Shared-Bus Conversion Controller

This block drives three four-channel simultaneous-sampling converters that hang on one serial clock line and one serial command line, each converter having its own active-low select. When the board enable goes high, the block writes a fixed configuration image into every converter, one converter after the other. Once that setup pass is over it reports that initialisation is done. A host may then read single registers back from a chosen converter.

Conversions are armed by a start command. After that, each selected trigger pulse fires one convert strobe shared by all three converters. The block waits for their busy lines to drop and then clocks both data outputs of every converter at the same time. It presents twelve 16-bit two's-complement channel words with a one-cycle valid strobe. Dropping the enable aborts any activity at once.

Top module: `adc_trio_ctrl`

## Requirements
- R1: Outside a conversion data read, at most one select line is low at any time. During a data read all three are low together. While idle all are high.
- R2: On a rising `enable`, every entry of the configuration image is sent to ADC0, then to ADC1, then to ADC2. Each entry is a 24-bit frame, MSB first: address byte with bit 23 forced to 0, then 16 data bits. SDO changes while SCLK is low and SCLK runs at the system clock divided by 4. `initDone` rises after the last frame.
- R3: A `rdReq` pulse while `initDone` is high and no conversion is running sends the frame {1'b1, rdAddr, 16'h0000} to the ADC numbered `rdAdc` only. The 16 bits that ADC returns on its DOUTA line during the last 16 SCLK periods appear on `rdData`, and `rdDone` is set at the same time. A new request clears `rdDone`.
- R4: `startCmd` arms conversions only while `initDone` is high. Triggers before arming produce no convert strobe.
- R5: With `trigSel` = 0 a trigger is a cycle with `userPulse` high. With `trigSel` = 1 it is a cycle with `timingPulse` high. The unselected pulse has no effect.
- R6: A trigger gives a one-cycle `convst`. Once all busy lines are low, 32 SCLK periods are run with all selects low, and DOUTA and DOUTB of all ADCs are captured MSB first. Channel 4k+0 is the first 16 DOUTA bits of ADC k, 4k+1 the next 16, 4k+2 the first 16 DOUTB bits and 4k+3 the next 16. Channel c sits at `chanData[16c +: 16]`. `chanValid` pulses for one cycle when the words update.
- R7: Trigger pulses while any busy line is high, or while a conversion is running, are ignored.
- R8: Within two cycles of `enable` going low, all selects are high, SCLK is low and `initDone` is 0. Arming is cleared, so no conversion occurs until a new setup and a new start.
- R9: After reset all selects are high, SCLK, `convst`, `initDone` and `chanValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Board conversion enable; rising edge starts setup |
| startCmd | input | 1 | Arm conversions (pulse) |
| trigSel | input | 1 | Trigger source: 0 user pulse, 1 timing pulse |
| userPulse | input | 1 | User-logic sampling pulse |
| timingPulse | input | 1 | Internal sampling timing pulse |
| rdReq | input | 1 | Register readback request (pulse) |
| rdAdc | input | 2 | Converter index for readback |
| rdAddr | input | 7 | Register address for readback |
| rdData | output | 16 | Last readback value |
| rdDone | output | 1 | Readback finished flag |
| sclk | output | 1 | Shared serial clock |
| sdo | output | 1 | Shared serial data to converters |
| csN | output | 3 | Per-converter active-low selects |
| convst | output | 1 | Shared convert strobe |
| busy | input | 3 | Per-converter busy lines |
| doutA | input | 3 | First serial data output of each converter |
| doutB | input | 3 | Second serial data output of each converter |
| chanData | output | 192 | Twelve 16-bit channel words |
| chanValid | output | 1 | One-cycle strobe for new channel words |
| initDone | output | 1 | Setup pass completed |

## Verification
Each setup frame takes 96 system cycles plus two cycles of select handling. The whole setup pass is therefore about 3 x 4 x 98 cycles, and the bench waits for `initDone` under a bounded limit before it compares the logged frames. `convst` follows a trigger by one cycle. Channel words arrive about 131 cycles after the busy lines fall, and readback data about 100 cycles after the request. The bench polls the valid or done flag away from the clock edge with a timeout instead of fixed offsets. The abort is sampled exactly two cycles after `enable` drops. That covers the select register and the one-cycle-later serial-engine abort.

// File: rtl/adc_trio_pkg.sv
`timescale 1ns/1ps
package adc_trio_pkg;
  localparam int FRAME_W = 24;
  localparam int DATA_W  = 32;
  localparam int CH_W    = 16;
  localparam int CNT_W   = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_CFG_GAP, S_READY, S_RD, S_RD_GAP, S_CONV, S_BUSYW, S_DATA
  } ctlState_t;

  typedef struct packed {
    logic               load;
    logic [FRAME_W-1:0] txWord;
    logic [CNT_W-1:0]   nBits;
    logic               rdLatch;
    logic [1:0]         rdSel;
    logic               chLatch;
    logic               abort;
  } ctlStrobe_t;
endpackage

// File: rtl/adc_trio_dp.sv
`timescale 1ns/1ps
module adc_trio_dp
  import adc_trio_pkg::*;
#(
  parameter int NUM_ADC = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strb,
  input  logic [NUM_ADC-1:0]            doutA,
  input  logic [NUM_ADC-1:0]            doutB,
  output logic                          sclk,
  output logic                          sdo,
  output logic                          engActive,
  output logic [CH_W-1:0]               rdData,
  output logic [NUM_ADC*4*CH_W-1:0]     chanData,
  output logic                          chanValid
);
  localparam int ADC_W = 4 * CH_W;

  logic [1:0]         phase;
  logic [CNT_W-1:0]   bitsLeft;
  logic [FRAME_W-1:0] txSh;
  logic               sampleNow;
  logic [CH_W-1:0]    rdLow [NUM_ADC];
  logic [CH_W-1:0]    rdPick;

  assign sdo       = txSh[FRAME_W-1];
  assign sampleNow = engActive && (phase == 2'd1) && !strb.abort;

  // Bit engine: four system cycles per bit, low half then high half.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      bitsLeft  <= '0;
      txSh      <= '0;
      engActive <= 1'b0;
      sclk      <= 1'b0;
    end else if (strb.abort) begin
      engActive <= 1'b0;
      sclk      <= 1'b0;
      phase     <= '0;
      txSh      <= '0;
    end else if (strb.load) begin
      txSh      <= strb.txWord;
      bitsLeft  <= strb.nBits;
      engActive <= 1'b1;
      phase     <= '0;
      sclk      <= 1'b0;
    end else if (engActive) begin
      phase <= phase + 2'd1;
      if (phase == 2'd1) sclk <= 1'b1;
      if (phase == 2'd3) begin
        sclk     <= 1'b0;
        txSh     <= {txSh[FRAME_W-2:0], 1'b0};
        bitsLeft <= bitsLeft - CNT_W'(1);
        if (bitsLeft == CNT_W'(1)) engActive <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NUM_ADC; k++) begin : g_adc
    logic [DATA_W-1:0] rxA;
    logic [DATA_W-1:0] rxB;
    logic [ADC_W-1:0]  chanReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxA <= '0;
        rxB <= '0;
      end else if (sampleNow) begin
        rxA <= {rxA[DATA_W-2:0], doutA[k]};
        rxB <= {rxB[DATA_W-2:0], doutB[k]};
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chanReg <= '0;
      else if (strb.chLatch)
        chanReg <= {rxB[CH_W-1:0], rxB[DATA_W-1:CH_W], rxA[CH_W-1:0], rxA[DATA_W-1:CH_W]};
    end

    assign rdLow[k] = rxA[CH_W-1:0];
    assign chanData[k*ADC_W +: ADC_W] = chanReg;
  end

  always_comb begin
    rdPick = '0;
    for (int k = 0; k < NUM_ADC; k++)
      if (strb.rdSel == 2'(k)) rdPick = rdLow[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      chanValid <= 1'b0;
    end else begin
      chanValid <= strb.chLatch;
      if (strb.rdLatch) rdData <= rdPick;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    chanValid |=> !chanValid); // R6
  AST_SCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclk) && !strb.abort) |=> sclk); // R2
endmodule

// File: rtl/adc_trio_ctl.sv
`timescale 1ns/1ps
module adc_trio_ctl
  import adc_trio_pkg::*;
#(
  parameter int                     NUM_ADC   = 3,
  parameter int                     NUM_CFG   = 4,
  parameter logic [NUM_CFG*24-1:0]  CFG_IMAGE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               startCmd,
  input  logic               trigSel,
  input  logic               userPulse,
  input  logic               timingPulse,
  input  logic               rdReq,
  input  logic [1:0]         rdAdc,
  input  logic [6:0]         rdAddr,
  input  logic [NUM_ADC-1:0] busy,
  input  logic               engActive,
  output ctlStrobe_t         strb,
  output logic [NUM_ADC-1:0] csN,
  output logic               convst,
  output logic               initDone,
  output logic               rdDone
);
  localparam int WIDX = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  ctlState_t         state;
  logic              enPrev;
  logic [1:0]        adcIdx;
  logic [WIDX-1:0]   wordIdx;
  logic              armed;
  logic [1:0]        guard;
  logic [1:0]        rdAdcR;

  logic              lastWord, lastAdc, trig, anyBusy, engDone, rdOk;
  logic [1:0]        nAdc;
  logic [WIDX-1:0]   nWord;
  logic [FRAME_W-1:0] nCfg;

  always_comb begin
    lastWord = (wordIdx == WIDX'(NUM_CFG-1));
    lastAdc  = (adcIdx == 2'(NUM_ADC-1));
    nAdc     = lastWord ? adcIdx + 2'd1 : adcIdx;
    nWord    = lastWord ? '0 : wordIdx + WIDX'(1);
    nCfg     = {1'b0, CFG_IMAGE[nWord*FRAME_W +: FRAME_W-1]};
    trig     = trigSel ? timingPulse : userPulse;
    anyBusy  = |busy;
    engDone  = !strb.load && !engActive;
    rdOk     = (rdAdc <= 2'(NUM_ADC-1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      enPrev   <= 1'b0;
      adcIdx   <= '0;
      wordIdx  <= '0;
      armed    <= 1'b0;
      guard    <= '0;
      rdAdcR   <= '0;
      csN      <= '1;
      convst   <= 1'b0;
      initDone <= 1'b0;
      rdDone   <= 1'b0;
      strb     <= '0;
    end else begin
      enPrev       <= enable;
      convst       <= 1'b0;
      strb.load    <= 1'b0;
      strb.rdLatch <= 1'b0;
      strb.chLatch <= 1'b0;
      strb.abort   <= 1'b0;
      if (!enable) begin
        state      <= S_IDLE;
        csN        <= '1;
        initDone   <= 1'b0;
        armed      <= 1'b0;
        strb.abort <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (!enPrev) begin
            adcIdx      <= '0;
            wordIdx     <= '0;
            csN         <= ~NUM_ADC'(1);
            strb.load   <= 1'b1;
            strb.txWord <= {1'b0, CFG_IMAGE[FRAME_W-2:0]};
            strb.nBits  <= CNT_W'(FRAME_W);
            state       <= S_CFG;
          end
          S_CFG: if (engDone) begin
            csN   <= '1;
            state <= S_CFG_GAP;
          end
          S_CFG_GAP: begin
            if (lastWord && lastAdc) begin
              initDone <= 1'b1;
              state    <= S_READY;
            end else begin
              adcIdx      <= nAdc;
              wordIdx     <= nWord;
              csN         <= ~(NUM_ADC'(1) << nAdc);
              strb.load   <= 1'b1;
              strb.txWord <= nCfg;
              strb.nBits  <= CNT_W'(FRAME_W);
              state       <= S_CFG;
            end
          end
          S_READY: begin
            if (rdReq && rdOk) begin
              rdDone      <= 1'b0;
              rdAdcR      <= rdAdc;
              csN         <= ~(NUM_ADC'(1) << rdAdc);
              strb.load   <= 1'b1;
              strb.txWord <= {1'b1, rdAddr, 16'h0000};
              strb.nBits  <= CNT_W'(FRAME_W);
              state       <= S_RD;
            end else if (startCmd) begin
              armed <= 1'b1;
            end else if (armed && trig && !anyBusy) begin
              convst <= 1'b1;
              state  <= S_CONV;
            end
          end
          S_RD: if (engDone) begin
            csN          <= '1;
            strb.rdLatch <= 1'b1;
            strb.rdSel   <= rdAdcR;
            state        <= S_RD_GAP;
          end
          S_RD_GAP: begin
            rdDone <= 1'b1;
            state  <= S_READY;
          end
          S_CONV: begin
            guard <= 2'd2;
            state <= S_BUSYW;
          end
          S_BUSYW: begin
            if (guard != 2'd0) guard <= guard - 2'd1;
            else if (!anyBusy) begin
              csN         <= '0;
              strb.load   <= 1'b1;
              strb.txWord <= '0;
              strb.nBits  <= CNT_W'(DATA_W);
              state       <= S_DATA;
            end
          end
          S_DATA: if (engDone) begin
            csN          <= '1;
            strb.chLatch <= 1'b1;
            state        <= S_READY;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_SHARED_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(~csN) <= 1) || (csN == '0)); // R1
  AST_CONVST_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rstN)
    convst |-> initDone); // R4
  AST_NO_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    anyBusy |=> !convst); // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (csN == '1) && !initDone); // R8
endmodule

// File: rtl/adc_trio_ctrl.sv
`timescale 1ns/1ps
module adc_trio_ctrl
  import adc_trio_pkg::*;
#(
  parameter int                    NUM_ADC   = 3,
  parameter int                    NUM_CFG   = 4,
  parameter logic [NUM_CFG*24-1:0] CFG_IMAGE = 96'h83C3A5_0200F0_018001_000A5C
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic                      startCmd,
  input  logic                      trigSel,
  input  logic                      userPulse,
  input  logic                      timingPulse,
  input  logic                      rdReq,
  input  logic [1:0]                rdAdc,
  input  logic [6:0]                rdAddr,
  output logic [15:0]               rdData,
  output logic                      rdDone,
  output logic                      sclk,
  output logic                      sdo,
  output logic [NUM_ADC-1:0]        csN,
  output logic                      convst,
  input  logic [NUM_ADC-1:0]        busy,
  input  logic [NUM_ADC-1:0]        doutA,
  input  logic [NUM_ADC-1:0]        doutB,
  output logic [NUM_ADC*64-1:0]     chanData,
  output logic                      chanValid,
  output logic                      initDone
);
  ctlStrobe_t strb;
  logic       engActive;

  adc_trio_ctl #(.NUM_ADC(NUM_ADC), .NUM_CFG(NUM_CFG), .CFG_IMAGE(CFG_IMAGE)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .startCmd(startCmd),
    .trigSel(trigSel), .userPulse(userPulse), .timingPulse(timingPulse),
    .rdReq(rdReq), .rdAdc(rdAdc), .rdAddr(rdAddr), .busy(busy),
    .engActive(engActive), .strb(strb), .csN(csN), .convst(convst),
    .initDone(initDone), .rdDone(rdDone)
  );

  adc_trio_dp #(.NUM_ADC(NUM_ADC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .doutA(doutA), .doutB(doutB),
    .sclk(sclk), .sdo(sdo), .engActive(engActive), .rdData(rdData),
    .chanData(chanData), .chanValid(chanValid)
  );
endmodule

// File: tb/adc_trio_ctrl_bench.sv
`timescale 1ns/1ps
module adc_trio_ctrl_bench;
  localparam int BUSY_LEN = 20;
  localparam logic [23:0] EXP_CFG [4] = '{24'h000A5C, 24'h018001, 24'h0200F0, 24'h03C3A5};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, startCmd = 1'b0, trigSel = 1'b0, userPulse = 1'b0, timingPulse = 1'b0;
  logic rdReq = 1'b0;
  logic [1:0] rdAdc = '0;
  logic [6:0] rdAddr = '0;
  logic [15:0] rdData;
  logic rdDone, sclk, sdo, convst, chanValid, initDone;
  logic [2:0] csN;
  logic [2:0] busy, doutA, doutB;
  logic [191:0] chanData;

  int checks = 0, errors = 0;
  int convstCnt = 0, validCnt = 0;
  logic [31:0] srcA [3];
  logic [31:0] srcB [3];
  logic [31:0] shA [3];
  logic [31:0] shB [3];
  int logN = 0, bc = 0;
  logic [23:0] cur;
  int logAdc [64];
  logic [23:0] logWord [64];

  always #2.5 clk = ~clk;

  adc_trio_ctrl u_adc_trio_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .startCmd(startCmd), .trigSel(trigSel),
    .userPulse(userPulse), .timingPulse(timingPulse), .rdReq(rdReq), .rdAdc(rdAdc),
    .rdAddr(rdAddr), .rdData(rdData), .rdDone(rdDone), .sclk(sclk), .sdo(sdo),
    .csN(csN), .convst(convst), .busy(busy), .doutA(doutA), .doutB(doutB),
    .chanData(chanData), .chanValid(chanValid), .initDone(initDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Converter model: shifts on SCLK falls, first bit valid at select fall; busy after convst.
  initial begin
    logic [2:0] prevCs;
    logic prevSclk;
    int busyLeft;
    prevCs = '1; prevSclk = 1'b0; busyLeft = 0;
    busy = '0; doutA = '0; doutB = '0;
    for (int k = 0; k < 3; k++) begin
      srcA[k] = '0; srcB[k] = '0; shA[k] = '0; shB[k] = '0;
    end
    forever begin
      @(posedge clk); #1;
      for (int k = 0; k < 3; k++) begin
        if (prevCs[k] && !csN[k]) begin
          shA[k] = srcA[k]; shB[k] = srcB[k];
        end else if (prevSclk && !sclk && !csN[k]) begin
          shA[k] = {shA[k][30:0], 1'b0}; shB[k] = {shB[k][30:0], 1'b0};
        end
        doutA[k] = shA[k][31];
        doutB[k] = shB[k][31];
      end
      prevCs = csN; prevSclk = sclk;
      if (convst) begin
        convstCnt++; busy = 3'b111; busyLeft = BUSY_LEN;
      end else if (busyLeft > 0) begin
        busyLeft--;
        if (busyLeft == 0) busy = '0;
      end
      if (chanValid) validCnt++;
    end
  end

  // Frame logger for single-select frames
  initial forever begin
    @(posedge sclk);
    if ($countones(~csN) == 1) begin
      cur = {cur[22:0], sdo};
      bc++;
      if (bc == 24) begin
        logAdc[logN] = !csN[0] ? 0 : (!csN[1] ? 1 : 2);
        logWord[logN] = cur;
        logN++;
        bc = 0;
      end
    end
  end
  initial forever begin
    @(posedge clk);
    if (csN == 3'b111) bc = 0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic waitInit(input string tag);
    int n = 0;
    while (!initDone && n < 3000) begin @(negedge clk); n++; end
    chk(tag, {31'd0, initDone}, 32'd1);
  endtask

  task automatic waitValid(input string tag);
    int n = 0;
    while (!chanValid && n < 600) begin @(negedge clk); n++; end
    chk(tag, {31'd0, chanValid}, 32'd1);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 csN", {29'd0, csN}, 32'h7);
    chk("R9 sclk", {31'd0, sclk}, 0);
    chk("R9 convst", {31'd0, convst}, 0);
    chk("R9 initDone", {31'd0, initDone}, 0);
    chk("R9 chanValid", {31'd0, chanValid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_config;
    realtime t0, t1;
    int base = logN;
    pulse(startCmd);
    pulse(userPulse);
    repeat (30) @(negedge clk);
    chk("R4 no convst before init", convstCnt, 0);
    @(negedge clk); enable = 1'b1;
    @(posedge sclk); t0 = $realtime;
    @(posedge sclk); t1 = $realtime;
    chk("R2 sclk period ns", int'(t1 - t0), 20);
    waitInit("R2 initDone");
    chk("R2 frame count", logN - base, 12);
    for (int i = 0; i < 12; i++) begin
      chk("R2 frame adc order", logAdc[base+i], i / 4);
      chk("R2 frame word", {8'd0, logWord[base+i]}, {8'd0, EXP_CFG[i % 4]});
    end
    chk("R1 idle selects", {29'd0, csN}, 32'h7);
    pulse(userPulse);
    repeat (30) @(negedge clk);
    chk("R4 no convst without start", convstCnt, 0);
  endtask

  task automatic t_readback;
    int n = 0;
    int base = logN;
    srcA[1] = {8'h00, 16'hBEEF, 8'h00};
    rdAdc = 2'd1; rdAddr = 7'h05;
    pulse(rdReq);
    while (!rdDone && n < 300) begin @(negedge clk); n++; end
    chk("R3 rdDone", {31'd0, rdDone}, 1);
    chk("R3 rdData", {16'd0, rdData}, 32'hBEEF);
    chk("R3 one frame", logN - base, 1);
    chk("R3 frame adc", logAdc[base], 1);
    chk("R3 frame word", {8'd0, logWord[base]}, 32'h850000);
    pulse(rdReq);
    @(negedge clk);
    chk("R3 rdDone cleared", {31'd0, rdDone}, 0);
    n = 0;
    while (!rdDone && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic loadSrc(input logic [7:0] seed);
    for (int k = 0; k < 3; k++) begin
      srcA[k] = {seed, 8'(k), 8'hA0, 8'(k) ^ seed};
      srcB[k] = {8'hF0 ^ seed, 8'(k+4), seed, 8'(k) + 8'h3C};
    end
  endtask

  task automatic checkChans(input string tag);
    for (int k = 0; k < 3; k++) begin
      chk({tag, " ch4k"},   {16'd0, chanData[(4*k)*16 +: 16]},   {16'd0, srcA[k][31:16]});
      chk({tag, " ch4k+1"}, {16'd0, chanData[(4*k+1)*16 +: 16]}, {16'd0, srcA[k][15:0]});
      chk({tag, " ch4k+2"}, {16'd0, chanData[(4*k+2)*16 +: 16]}, {16'd0, srcB[k][31:16]});
      chk({tag, " ch4k+3"}, {16'd0, chanData[(4*k+3)*16 +: 16]}, {16'd0, srcB[k][15:0]});
    end
  endtask

  task automatic t_conv_sel(input logic sel, input logic [7:0] seed);
    int c0 = convstCnt;
    trigSel = sel;
    loadSrc(seed);
    pulse(startCmd);
    if (sel) pulse(userPulse); else pulse(timingPulse);
    repeat (30) @(negedge clk);
    chk("R5 unselected pulse ignored", convstCnt - c0, 0);
    if (sel) pulse(timingPulse); else pulse(userPulse);
    waitValid("R6 valid arrives");
    chk("R6 one convst", convstCnt - c0, 1);
    checkChans(sel ? "R6 timing" : "R6 user");
    @(negedge clk);
    chk("R6 valid one cycle", {31'd0, chanValid}, 0);
  endtask

  task automatic t_busy_ignore;
    int c0 = convstCnt, v0 = validCnt;
    trigSel = 1'b1;
    pulse(timingPulse);
    repeat (3) @(negedge clk);
    pulse(timingPulse);
    repeat (60) @(negedge clk);
    pulse(timingPulse);
    repeat (300) @(negedge clk);
    chk("R7 single convst", convstCnt - c0, 1);
    chk("R7 single result", validCnt - v0, 1);
  endtask

  task automatic t_abort;
    int c0;
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    repeat (40) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 selects high", {29'd0, csN}, 32'h7);
    chk("R8 sclk low", {31'd0, sclk}, 0);
    chk("R8 initDone cleared", {31'd0, initDone}, 0);
    c0 = convstCnt;
    pulse(startCmd);
    pulse(timingPulse);
    repeat (20) @(negedge clk);
    chk("R8 no convst while disabled", convstCnt - c0, 0);
    @(negedge clk); enable = 1'b1;
    waitInit("R8 re-init");
    pulse(timingPulse);
    repeat (30) @(negedge clk);
    chk("R8 arming cleared", convstCnt - c0, 0);
  endtask

  initial begin
    t_reset();
    t_config();
    t_readback();
    t_conv_sel(1'b0, 8'h5A);
    t_conv_sel(1'b1, 8'hC3);
    t_busy_ignore();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule